// File: doc/BRIEF.md
# Countdown Timer with Routed Interrupt Line

This block is a memory-mapped down-counter for a small microcontroller. Software picks one of sixteen interrupt lines, a mask and a repeat mode through a control register, then writes a start value into the initial-count register. The counter decrements once per input clock. When it reaches zero, it raises a single-clock event on the chosen line, unless that line is masked. It then either reloads itself or halts.

The interrupt lines go to a separate interrupt controller, which is not part of this block. The timer only selects which line carries its event. It has no vector number and no trigger options. A third register returns the live count and cannot be written. Bus reads are combinational on the address. Writes take effect on the rising clock edge where `bus_wr` is high.

Top module: `line_countdown_timer`

## Requirements
- R1: After reset, the control register (word address 0) reads 0x0001_0000, which means masked, one-shot, line 0. The initial count (address 1) and the current count (address 2) read 0, and `irq_lines` is all zero.
- R2: The control register keeps only bits 3:0 (line select), bit 16 (mask, 1 = masked) and bit 17 (mode, 1 = periodic, 0 = one-shot). All other bits read back as zero.
- R3: A write of N to address 1 makes the current count read N after that edge. The count then falls by one on each following clock.
- R4: Suppose the count reads zero in a clock cycle while the timer runs unmasked. Then, after the next edge, exactly one `irq_lines` bit is high for one clock: the bit numbered by control bits 3:0.
- R5: In periodic mode, the clock after the count reads zero reloads it from the initial count. With an initial count of N, events repeat every N+1 clocks.
- R6: In one-shot mode, the count stays at zero after it expires, and no further event occurs.
- R7: While the mask bit is set, no event is produced, but counting and periodic reloading carry on.
- R8: Writing 0 to address 1 stops the timer. The current count reads 0 and no further event occurs.
- R9: Writing a new initial count while the timer runs restarts the countdown from the new value, and the old countdown raises no event.
- R10: Address 1 reads back the last value written to it. Writes to address 2 have no effect. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 initial count, 2 current count |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq_lines | output | 2**LINE_SEL_W | One-clock event on the selected interrupt line |

## Verification
The properties assume that `bus_wr` and `bus_addr` are known at every edge after reset. They also assume that a running timer always holds a nonzero initial count, which the block guarantees because a zero write halts it. The rule that events never come on consecutive clocks depends on software not forcing a reload of 0 while the timer runs. The stimulus changes inputs only on falling edges. It places every initial-count write on an edge where the count is nonzero, so no restart or stop collides with an expiry cycle.

// File: rtl/line_tmr_pkg.sv
package line_tmr_pkg;
  localparam int LINE_SEL_W = 4;
  localparam int MASK_POS   = 16;
  localparam int MODE_POS   = 17;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_INIT   = 1;
  localparam int ADR_CUR    = 2;

  typedef struct packed {
    logic                  periodic;
    logic                  masked;
    logic [LINE_SEL_W-1:0] line;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import line_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cur_count,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  init_q,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  bus_rdata
);
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] init_d;
  logic             ctrl_we, init_we;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign init_we = bus_wr && (bus_addr == ADDR_W'(ADR_INIT));

  always_comb begin
    ctrl_d = ctrl_q;
    init_d = init_q;
    if (ctrl_we) begin
      ctrl_d.line     = bus_wdata[LINE_SEL_W-1:0];
      ctrl_d.masked   = bus_wdata[MASK_POS];
      ctrl_d.periodic = bus_wdata[MODE_POS];
    end
    if (init_we) begin
      init_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.line     <= '0;
      ctrl_q.masked   <= 1'b1;
      ctrl_q.periodic <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
    end else if (init_we) begin
      init_q <= init_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign load_en  = init_we;
  assign load_val = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(ADR_CTRL): begin
        bus_rdata[LINE_SEL_W-1:0] = ctrl_q.line;
        bus_rdata[MASK_POS]       = ctrl_q.masked;
        bus_rdata[MODE_POS]       = ctrl_q.periodic;
      end
      ADDR_W'(ADR_INIT): bus_rdata = init_q;
      ADDR_W'(ADR_CUR):  bus_rdata = cur_count;
      default:           bus_rdata = '0;
    endcase
  end

  // R10: the initial-count register changes only through a write to its address
  p_init_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_we |=> init_q == $past(init_q));

  // R2: a control write stores its mode and mask bits
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.masked == $past(bus_wdata[MASK_POS])) &&
                (ctrl_q.periodic == $past(bus_wdata[MODE_POS])));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  logic [CNT_W-1:0] cur_d;
  logic             run_q, run_d;
  logic             cnt_en;
  logic             at_zero;

  assign at_zero = (cur_q == '0);
  assign expire  = run_q && at_zero;
  assign cnt_en  = load_en || run_q;

  always_comb begin
    cur_d = cur_q;
    run_d = run_q;
    if (load_en) begin
      cur_d = load_val;
      run_d = (load_val != '0);
    end else if (run_q) begin
      if (at_zero) begin
        if (periodic) begin
          cur_d = reload_val;
        end else begin
          run_d = 1'b0;
        end
      end else begin
        cur_d = cur_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cur_q <= cur_d;
      run_q <= run_d;
    end
  end

  // R3: a running nonzero count falls by exactly one per clock
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_zero && !load_en) |=> cur_q == $past(cur_q) - CNT_W'(1));

  // R9: a write loads the new value regardless of the count in progress
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cur_q == $past(load_val));

  // R5: periodic expiry reloads from the initial count
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !load_en) |=> cur_q == $past(reload_val));

  // R6: one-shot expiry leaves the counter halted at zero
  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !load_en) |=> (cur_q == '0) && !expire);
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
  parameter int LINE_SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic                      masked,
  input  logic [LINE_SEL_W-1:0]     line_sel,
  output logic [(1<<LINE_SEL_W)-1:0] irq_q
);
  localparam int LINES = 1 << LINE_SEL_W;

  logic [LINES-1:0] irq_d;
  logic             pass;

  assign pass = fire && !masked;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign irq_d[g] = pass && (line_sel == LINE_SEL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  // R4: at most one line carries the event
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));

  // R4: the event lasts a single clock
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q != '0) |=> (irq_q == '0));

  // R7: a masked timer never drives a line
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> (irq_q == '0));
endmodule

// File: rtl/line_countdown_timer.sv
module line_countdown_timer
  import line_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [CNT_W-1:0]          bus_wdata,
  output logic [CNT_W-1:0]          bus_rdata,
  output logic [(1<<LINE_SEL_W)-1:0] irq_lines
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] init_q;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cur_q;
  logic             expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cur_count (cur_q),
    .ctrl      (ctrl),
    .init_q    (init_q),
    .load_en   (load_en),
    .load_val  (load_val),
    .bus_rdata (bus_rdata)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_en    (load_en),
    .load_val   (load_val),
    .reload_val (init_q),
    .periodic   (ctrl.periodic),
    .cur_q      (cur_q),
    .expire     (expire)
  );

  tmr_irq_route #(.LINE_SEL_W(LINE_SEL_W)) route_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .fire     (expire),
    .masked   (ctrl.masked),
    .line_sel (ctrl.line),
    .irq_q    (irq_lines)
  );
endmodule

// File: tb/line_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module line_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines;

  always #2.5 clk = ~clk;

  line_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines)
  );

  typedef struct {
    int unsigned at;
    logic [15:0] vec;
    string       tag;
  } pulse_t;

  pulse_t      exp_q[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the interrupt lines against the expected events
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        pulse_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (irq_lines !== e.vec) begin
          n_fail++;
          $display("FAIL %s: irq_lines at cycle %0d got %h expected %h", e.tag, cyc, irq_lines, e.vec);
        end
      end else if (irq_lines !== 16'h0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R4/R6/R7/R8: unexpected event at cycle %0d got %h expected 0000", cyc, irq_lines);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d, output int unsigned p);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    p = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic push(input int unsigned at, input logic [15:0] v, input string tag);
    pulse_t e;
    e.at = at; e.vec = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000.0 * 5.0);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    int unsigned p, p2;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1: reset state
    read_chk(2'd0, 32'h0001_0000, "R1");
    read_chk(2'd1, 32'h0, "R1");
    read_chk(2'd2, 32'h0, "R1");
    n_chk++;
    if (irq_lines !== 16'h0) begin
      n_fail++;
      $display("FAIL R1: irq_lines got %h expected 0000", irq_lines);
    end

    // R2: only line, mask and mode bits are kept
    bus_write(2'd0, 32'hFFFF_FFFF, p);
    read_chk(2'd0, 32'h0003_000F, "R2");

    // R4/R3/R6: one-shot, line 5, count 4
    bus_write(2'd0, 32'h0000_0005, p);
    bus_write(2'd1, 32'd4, p);
    push(p + 5, 16'h0020, "R4");
    read_chk(2'd2, 32'd4, "R3");
    @(negedge clk);
    read_chk(2'd2, 32'd3, "R3");
    drain();
    repeat (10) @(negedge clk);
    read_chk(2'd2, 32'd0, "R6");

    // R4 boundary: count 1 on line 0
    bus_write(2'd0, 32'h0000_0000, p);
    bus_write(2'd1, 32'd1, p);
    push(p + 2, 16'h0001, "R4");
    drain();

    // R5: periodic, line 12, count 3
    bus_write(2'd0, 32'h0002_000C, p);
    read_chk(2'd0, 32'h0002_000C, "R2");
    bus_write(2'd1, 32'd3, p);
    push(p + 4, 16'h1000, "R5");
    push(p + 8, 16'h1000, "R5");
    push(p + 12, 16'h1000, "R5");
    read_chk(2'd1, 32'd3, "R10");
    drain();
    // R8: stop with zero
    bus_write(2'd1, 32'd0, p);
    read_chk(2'd2, 32'd0, "R8");
    repeat (20) @(negedge clk);
    read_chk(2'd2, 32'd0, "R8");

    // R7: masked periodic, count keeps cycling, no events
    bus_write(2'd0, 32'h0003_0002, p);
    bus_write(2'd1, 32'd2, p);
    read_chk(2'd2, 32'd2, "R7");
    @(negedge clk); read_chk(2'd2, 32'd1, "R7");
    @(negedge clk); read_chk(2'd2, 32'd0, "R7");
    @(negedge clk); read_chk(2'd2, 32'd2, "R7");
    repeat (9) @(negedge clk);
    bus_write(2'd1, 32'd0, p);

    // R9: restart while counting, one-shot line 15
    bus_write(2'd0, 32'h0000_000F, p);
    bus_write(2'd1, 32'd10, p);
    repeat (3) @(negedge clk);
    bus_write(2'd1, 32'd6, p2);
    read_chk(2'd2, 32'd6, "R9");
    push(p2 + 7, 16'h8000, "R9");
    drain();
    repeat (15) @(negedge clk);

    // R10: current count is read-only, unused address reads zero
    bus_write(2'd2, 32'h0000_0055, p);
    read_chk(2'd2, 32'd0, "R10");
    read_chk(2'd1, 32'd6, "R10");
    read_chk(2'd3, 32'd0, "R10");

    // R3 boundary: full-width load
    bus_write(2'd1, 32'hFFFF_FFFF, p);
    read_chk(2'd2, 32'hFFFF_FFFF, "R3");
    @(negedge clk);
    read_chk(2'd2, 32'hFFFF_FFFE, "R3");
    bus_write(2'd1, 32'd0, p);
    read_chk(2'd2, 32'd0, "R8");

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4: %0d expected events missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule